// File: doc/BRIEF.md
# Descriptor Queue Interlock Engine

This block is the device-side controller for a ring of fixed-size command descriptors kept in host memory. Each descriptor opens with one 32-bit big-endian interlock word that packs a 16-bit header CRC, a byte of flags owned by the hardware and a byte of flags owned by software. Software fills a descriptor, sets its "may advance" flag and rings the doorbell. The engine then claims the entry by setting a fetched flag. It validates the preamble and header CRC, hands the command to an execution unit through a start/done handshake and writes back a return code. Finally it sets a completed flag and, if software asked for one, pulses an interrupt.

Every update of the interlock word is a whole 32-bit read-modify-write, so software can use a 32-bit compare-and-swap on the same word. A purge flag lets software cancel an entry without running it. A bad preamble or a CRC mismatch halts the queue with a sticky error. After a completion the engine moves straight on to the next slot and wraps at the end of the ring, so a run of prepared entries needs a single doorbell.

Top module: `dq_interlock_engine`

## Requirements
- R1: After reset, mem_req, exec_start, irq, err and busy are all low.
- R2: On a doorbell with err low, the engine reads the interlock word (word 0) of the current slot. It takes the entry only when software flag bit 0 (advance) is set and word bit 10 (fetched) is clear. Otherwise it writes nothing, returns to idle and keeps the same slot.
- R3: To take an entry, the engine writes back word 0 exactly as read, with bit 10 set.
- R4: Word 1 bits [31:24] must hold 0x80. Any other value sets err and leaves the entry fetched but not completed, with no exec_start and no return-code write.
- R5: The CRC-16 (polynomial 0x1021, seed 0xFFFF, most significant bit first) over the bytes of words 1 to 6+PARAM_WORDS, taken most significant byte first, must equal word 0 bits [31:16]. A mismatch is treated as in R4. Words beyond that range are not covered.
- R6: A valid entry without purge gives one exec_start pulse, with exec_cmd = word 2 bits [23:16] and exec_seq = word 1 bits [15:0]. After exec_done, exec_retc is written to bits [31:16] of word ENTRY_WORDS-1, with zero in bits [15:0].
- R7: A valid entry with software flag bit 1 (purge) set gives no exec_start, and its return word is written as 0x00F10000.
- R8: Completion re-reads word 0 and writes it back with bit 14 (completed) set and all other bits as re-read. irq pulses for exactly one cycle right after that write if, and only if, software flag bit 2 (interrupt) was set.
- R9: After a completion the engine examines the next slot without a further doorbell, and slot SLOTS-1 is followed by slot 0.
- R10: err stays high until err_clr. While err is high, doorbells are ignored and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| doorbell | input | 1 | Start pulse from software |
| err_clr | input | 1 | Clears the sticky error flag |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| exec_start | output | 1 | One-cycle command start |
| exec_cmd | output | 8 | Command byte of the entry |
| exec_seq | output | 16 | Sequence number of the entry |
| exec_done | input | 1 | Command finished |
| exec_retc | input | 16 | Return code, sampled with exec_done |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Sticky preamble/CRC error |
| busy | output | 1 | Engine is not idle |

## Verification
A wrong slot pointer shows up as a completion flag written into the wrong descriptor, or a ready entry left untouched. This is visible in memory as soon as the doorbell run ends. A corrupted captured flag byte or return code appears in the written-back interlock and return words, or as a missing or extra irq pulse within a few cycles of completion. A CRC or preamble path that accepts bad data shows up as a completed entry with err low, where the bench expects err high and the entry only fetched.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam logic [15:0] CRC_POLY     = 16'h1021;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [7:0]  PREAMBLE     = 8'h80;
    localparam int          SW_ADVANCE   = 0;
    localparam int          SW_PURGE     = 1;
    localparam int          SW_INTR      = 2;
    localparam logic [31:0] HW_FETCHED   = 32'h0000_0400;
    localparam logic [31:0] HW_COMPLETED = 32'h0000_4000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IL_RD,
        ST_IL_W,
        ST_FETCH_WR,
        ST_BODY_RD,
        ST_BODY_W,
        ST_CHECK,
        ST_EXEC_GO,
        ST_EXEC_WAIT,
        ST_RETC_WR,
        ST_DONE_RD,
        ST_DONE_W,
        ST_DONE_WR
    } dq_state_e;

    // One 32-bit word folded into the running CRC, most significant bit first
    function automatic logic [15:0] crc16_word(input logic [15:0] seed, input logic [31:0] w);
        logic [15:0] c;
        logic        fb;
        c = seed;
        for (int i = 31; i >= 0; i--) begin
            fb = c[15] ^ w[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/dq_crc_acc.sv
module dq_crc_acc
    import dq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [31:0] word,
    output logic [15:0] crc
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)    crc_d = CRC_SEED;
        else if (upd) crc_d = crc16_word(crc_q, word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/dq_ring_ptr.sv
module dq_ring_ptr #(
    parameter int SLOTS  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot
);

    logic [SLOT_W-1:0] slot_d, slot_q, slot_inc;

    generate
        if (SLOTS > 1 && (SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
            assign slot_inc = slot_q + 1'b1;
        end else begin : g_cmp
            assign slot_inc = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
        end
    endgenerate

    always_comb begin
        slot_d = slot_q;
        if (adv) slot_d = slot_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;

    // R9: pointer never leaves the ring
    a_r9_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(slot_q) < SLOTS);

    // R9: advancing from the top slot lands on slot 0
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && slot_q == SLOT_W'(SLOTS - 1)) |=> (slot_q == '0));

endmodule

// File: rtl/dq_interlock_engine.sv
module dq_interlock_engine
    import dq_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          BASE_WORD   = 0,
    parameter int          SLOTS       = 4,
    parameter int          ENTRY_WORDS = 16,
    parameter int          PARAM_WORDS = 2,
    parameter logic [15:0] PURGE_RETC  = 16'h00F1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          doorbell,
    input  logic          err_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          exec_start,
    output logic [7:0]    exec_cmd,
    output logic [15:0]   exec_seq,
    input  logic          exec_done,
    input  logic [15:0]   exec_retc,
    output logic          irq,
    output logic          err,
    output logic          busy
);

    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int IDX_W     = $clog2(ENTRY_WORDS);
    localparam int LAST_BODY = 6 + PARAM_WORDS;
    localparam int RETC_OFF  = ENTRY_WORDS - 1;

    typedef struct packed {
        dq_state_e   st;
        logic [IDX_W-1:0] idx;
        logic [31:0] il;
        logic [15:0] crc_exp;
        logic [2:0]  swf;
        logic [7:0]  cmd;
        logic [15:0] seq;
        logic [15:0] retc;
        logic        err;
        logic        irq;
    } eng_t;

    eng_t r_q, r_d;

    logic              crc_clr, crc_upd, adv;
    logic [15:0]       crc_now;
    logic [SLOT_W-1:0] slot;
    logic [AW-1:0]     slot_base;

    dq_ring_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .slot (slot)
    );

    dq_crc_acc u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(crc_clr),
        .upd  (crc_upd),
        .word (mem_rdata),
        .crc  (crc_now)
    );

    assign slot_base = AW'(BASE_WORD) + AW'(slot) * AW'(ENTRY_WORDS);

    always_comb begin
        r_d        = r_q;
        r_d.irq    = 1'b0;
        crc_clr    = 1'b0;
        crc_upd    = 1'b0;
        adv        = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = slot_base;
        mem_wdata  = '0;
        exec_start = 1'b0;
        if (err_clr) r_d.err = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (doorbell && !r_q.err) r_d.st = ST_IL_RD;
            end
            ST_IL_RD: begin
                mem_req = 1'b1;
                r_d.st  = ST_IL_W;
            end
            ST_IL_W: begin
                r_d.il = mem_rdata;
                if (mem_rdata[SW_ADVANCE] && (mem_rdata & HW_FETCHED) == '0) begin
                    r_d.crc_exp = mem_rdata[31:16];
                    r_d.swf     = mem_rdata[2:0];
                    r_d.st      = ST_FETCH_WR;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_FETCH_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.il | HW_FETCHED;
                crc_clr   = 1'b1;
                r_d.idx   = IDX_W'(1);
                r_d.st    = ST_BODY_RD;
            end
            ST_BODY_RD: begin
                mem_req  = 1'b1;
                mem_addr = slot_base + AW'(r_q.idx);
                r_d.st   = ST_BODY_W;
            end
            ST_BODY_W: begin
                crc_upd = 1'b1;
                if (r_q.idx == IDX_W'(1)) r_d.seq = mem_rdata[15:0];
                if (r_q.idx == IDX_W'(2)) r_d.cmd = mem_rdata[23:16];
                if (r_q.idx == IDX_W'(1) && mem_rdata[31:24] != PREAMBLE) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (r_q.idx == IDX_W'(LAST_BODY)) begin
                    r_d.st = ST_CHECK;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_BODY_RD;
                end
            end
            ST_CHECK: begin
                if (crc_now != r_q.crc_exp) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (r_q.swf[SW_PURGE]) begin
                    r_d.retc = PURGE_RETC;
                    r_d.st   = ST_RETC_WR;
                end else begin
                    r_d.st = ST_EXEC_GO;
                end
            end
            ST_EXEC_GO: begin
                exec_start = 1'b1;
                r_d.st     = ST_EXEC_WAIT;
            end
            ST_EXEC_WAIT: begin
                if (exec_done) begin
                    r_d.retc = exec_retc;
                    r_d.st   = ST_RETC_WR;
                end
            end
            ST_RETC_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_base + AW'(RETC_OFF);
                mem_wdata = {r_q.retc, 16'h0000};
                r_d.st    = ST_DONE_RD;
            end
            ST_DONE_RD: begin
                mem_req = 1'b1;
                r_d.st  = ST_DONE_W;
            end
            ST_DONE_W: begin
                r_d.il = mem_rdata;
                r_d.st = ST_DONE_WR;
            end
            ST_DONE_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.il | HW_COMPLETED;
                r_d.irq   = r_q.swf[SW_INTR];
                adv       = 1'b1;
                r_d.st    = ST_IL_RD;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign exec_cmd = r_q.cmd;
    assign exec_seq = r_q.seq;
    assign irq      = r_q.irq;
    assign err      = r_q.err;
    assign busy     = (r_q.st != ST_IDLE);

    // R3: every write of an interlock word carries the fetched bit
    a_r3_il_write_fetched: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == slot_base) |-> (mem_wdata[10] == 1'b1));

    // R6: the start strobe is a single cycle
    a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    // R8: interrupt lasts one cycle
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: interrupt only follows a completion write
    a_r8_irq_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_wdata[14]));

    // R10: a halted queue makes no access and starts nothing
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !exec_start));

    // R2: idle engine makes no memory access
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/dq_interlock_engine_tb.sv
module dq_interlock_engine_tb;

    localparam int AW       = 16;
    localparam int SLOTS    = 4;
    localparam int EW       = 16;
    localparam int PW       = 2;
    localparam int LASTW    = 6 + PW;
    localparam int MEMW     = SLOTS * EW;
    localparam int EXEC_LAT = 3;

    typedef struct packed {
        logic       pf;
        logic [2:0] swf;
        logic       bp;
        logic       bc;
        logic [7:0] cmd;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 3'b001, 1'b0, 1'b0, 8'h21},
        '{1'b0, 3'b101, 1'b0, 1'b0, 8'h22},
        '{1'b0, 3'b011, 1'b0, 1'b0, 8'h23},
        '{1'b0, 3'b111, 1'b0, 1'b0, 8'h24},
        '{1'b0, 3'b001, 1'b0, 1'b0, 8'h25},
        '{1'b0, 3'b100, 1'b0, 1'b0, 8'h26},
        '{1'b1, 3'b001, 1'b0, 1'b0, 8'h27},
        '{1'b0, 3'b001, 1'b1, 1'b0, 8'h28},
        '{1'b0, 3'b001, 1'b0, 1'b1, 8'h29},
        '{1'b0, 3'b101, 1'b0, 1'b0, 8'h2A}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          doorbell = 1'b0;
    logic          err_clr = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          exec_start;
    logic [7:0]    exec_cmd;
    logic [15:0]   exec_seq;
    logic          exec_done = 1'b0;
    logic [15:0]   exec_retc = '0;
    logic          irq, err, busy;

    logic [31:0] mem [MEMW];
    int          rd_cnt [MEMW];
    int          irq_total = 0;
    int          exec_total = 0;
    int          ex_cnt = 0;
    logic [7:0]  ex_cmd_seen = '0;
    logic [15:0] ex_seq_seen = '0;
    logic        tb_we = 1'b0;
    logic [5:0]  tb_addr = '0;
    logic [31:0] tb_wdata = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ent [EW];

    always #5 clk = ~clk;

    dq_interlock_engine #(
        .AW(AW), .BASE_WORD(0), .SLOTS(SLOTS), .ENTRY_WORDS(EW),
        .PARAM_WORDS(PW), .PURGE_RETC(16'h00F1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .err_clr(err_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .exec_start(exec_start), .exec_cmd(exec_cmd), .exec_seq(exec_seq),
        .exec_done(exec_done), .exec_retc(exec_retc),
        .irq(irq), .err(err), .busy(busy)
    );

    initial begin
        for (int k = 0; k < MEMW; k++) begin
            mem[k]    = '0;
            rd_cnt[k] = 0;
        end
    end

    // host memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[5:0]];
                rd_cnt[mem_addr[5:0]] <= rd_cnt[mem_addr[5:0]] + 1;
            end
        end
        if (tb_we) mem[tb_addr] <= tb_wdata;
        if (irq) irq_total <= irq_total + 1;
    end

    // command executor stand-in
    always @(posedge clk) begin
        if (exec_start) begin
            ex_cnt      <= EXEC_LAT;
            ex_cmd_seen <= exec_cmd;
            ex_seq_seen <= exec_seq;
            exec_total  <= exec_total + 1;
        end else if (ex_cnt > 0) begin
            ex_cnt <= ex_cnt - 1;
        end
        exec_done <= (ex_cnt == 1);
        exec_retc <= {8'hC0, ex_cmd_seen};
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc();
        logic [15:0] c;
        logic [7:0]  by;
        c = 16'hFFFF;
        for (int k = 1; k <= LASTW; k++) begin
            for (int b = 0; b < 4; b++) begin
                by = ent[k][31 - 8*b -: 8];
                c  = c ^ {by, 8'h00};
                for (int t = 0; t < 8; t++) begin
                    if (c[15]) c = {c[14:0], 1'b0} ^ 16'h1021;
                    else       c = {c[14:0], 1'b0};
                end
            end
        end
        return c;
    endfunction

    task automatic tbw(input int a, input logic [31:0] d);
        tb_we    = 1'b1;
        tb_addr  = 6'(a);
        tb_wdata = d;
        @(negedge clk);
        tb_we    = 1'b0;
    endtask

    task automatic write_entry(input int slot, input logic pf, input logic [2:0] swf,
                               input logic bp, input logic bc, input logic [7:0] cmd,
                               input logic [15:0] seq);
        logic [15:0] c;
        for (int k = 0; k < EW; k++) ent[k] = '0;
        ent[1] = {(bp ? 8'h7F : 8'h80), 8'h00, seq};
        ent[2] = {8'h05, cmd, 16'h0000};
        for (int k = 3; k <= LASTW; k++) ent[k] = 32'h1357_0000 + 32'(slot * 256 + k * 17);
        c = ref_crc();
        if (bc) c = c ^ 16'h0001;
        ent[0] = {c, (pf ? 8'h04 : 8'h00), 5'b0, swf};
        for (int k = 0; k < EW; k++) tbw(slot * EW + k, ent[k]);
    endtask

    task automatic ring();
        doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=hung expected=idle");
        summary();
        $finish;
    end

    initial begin
        int          es;
        int          irq0, ex0, rd0;
        logic [31:0] w0, wexp;
        logic        taken, bad, done;
        string       tag;
        es = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 irq/err/busy/start", {28'b0, irq, err, busy, exec_start}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            write_entry(es, VECS[i].pf, VECS[i].swf, VECS[i].bp, VECS[i].bc,
                        VECS[i].cmd, 16'h0100 + 16'(i));
            tbw(((es + 1) % SLOTS) * EW, 32'h0);
            w0    = mem[es * EW];
            irq0  = irq_total;
            ex0   = exec_total;
            ring();
            taken = VECS[i].swf[0] && !VECS[i].pf;
            bad   = taken && (VECS[i].bp || VECS[i].bc);
            done  = taken && !bad;
            wexp  = w0 | (taken ? 32'h0400 : 32'h0) | (done ? 32'h4000 : 32'h0);
            tag   = !taken ? "R2 not taken" : (VECS[i].bp ? "R4 preamble" :
                    (VECS[i].bc ? "R5 crc" : (i == 4 ? "R9 wrap slot0" : "R3/R8 interlock")));
            chk(tag, mem[es * EW], wexp);
            chk("R4/R5 err", {31'b0, err}, {31'b0, bad});
            chk("R8 irq count", 32'(irq_total - irq0), {31'b0, done && VECS[i].swf[2]});
            chk("R6/R7 exec count", 32'(exec_total - ex0), {31'b0, done && !VECS[i].swf[1]});
            if (done && VECS[i].swf[1])
                chk("R7 purge retc", mem[es * EW + EW - 1], 32'h00F1_0000);
            else if (done) begin
                chk("R6 retc", mem[es * EW + EW - 1], {8'hC0, VECS[i].cmd, 16'h0});
                chk("R6 cmd/seq", {8'h0, ex_cmd_seen, ex_seq_seen},
                    {8'h0, VECS[i].cmd, 16'h0100 + 16'(i)});
            end else
                chk("R4/R2 no retc", mem[es * EW + EW - 1], 32'h0);
            if (bad) begin
                pulse_clr();
                chk("R10 err cleared", {31'b0, err}, 32'd0);
            end
            if (done) es = (es + 1) % SLOTS;
        end

        // R10: halted queue ignores doorbell
        write_entry(es, 1'b0, 3'b001, 1'b0, 1'b1, 8'h31, 16'h0200);
        ring();
        chk("R10 err set", {31'b0, err}, 32'd1);
        write_entry(es, 1'b0, 3'b001, 1'b0, 1'b0, 8'h32, 16'h0201);
        w0  = mem[es * EW];
        rd0 = rd_cnt[es * EW];
        ring();
        repeat (10) @(negedge clk);
        chk("R10 no access while err", 32'(rd_cnt[es * EW] - rd0), 32'd0);
        chk("R10 entry untouched", mem[es * EW], w0);
        chk("R10 err sticky", {31'b0, err}, 32'd1);
        pulse_clr();
        tbw(((es + 1) % SLOTS) * EW, 32'h0);
        ring();
        chk("R10 runs after clear", mem[es * EW], w0 | 32'h4400);
        es = (es + 1) % SLOTS;

        // R9: two ready entries, one doorbell
        write_entry(es, 1'b0, 3'b001, 1'b0, 1'b0, 8'h41, 16'h0300);
        write_entry((es + 1) % SLOTS, 1'b0, 3'b001, 1'b0, 1'b0, 8'h42, 16'h0301);
        tbw(((es + 2) % SLOTS) * EW, 32'h0);
        ex0 = exec_total;
        ring();
        chk("R9 chain first", {16'h0, mem[es * EW][15:0]}, 32'h0000_4401);
        chk("R9 chain second", {16'h0, mem[((es + 1) % SLOTS) * EW][15:0]}, 32'h0000_4401);
        chk("R9 chain exec count", 32'(exec_total - ex0), 32'd2);
        es = (es + 2) % SLOTS;

        // R5: last covered parameter word altered -> error
        write_entry(es, 1'b0, 3'b001, 1'b0, 1'b0, 8'h51, 16'h0400);
        tbw(es * EW + LASTW, ent[LASTW] ^ 32'h0000_0100);
        ring();
        chk("R5 last covered word", {31'b0, err}, 32'd1);
        pulse_clr();

        // R5: first uncovered word altered -> no error
        write_entry(es, 1'b0, 3'b001, 1'b0, 1'b0, 8'h52, 16'h0401);
        tbw(es * EW + LASTW + 1, 32'hFFFF_FFFF);
        tbw(((es + 1) % SLOTS) * EW, 32'h0);
        ring();
        chk("R5 uncovered word err", {31'b0, err}, 32'd0);
        chk("R5 uncovered word done", {16'h0, mem[es * EW][15:0]}, 32'h0000_4401);

        summary();
        $finish;
    end

endmodule